// File: doc/BRIEF.md
# Fetch Group Extractor

This block turns one instruction-cache line into a fetch group for the decode queue. When a fetch request arrives, it takes the fetch PC, the whole cache line and a fault flag, all in the same cycle. It walks the line one 32-bit instruction per cycle. The walk starts at the word the PC points to and produces up to `FETCH_W` instructions. Each instruction is tagged with its own PC, its predicted next PC and a sequence number drawn from a counter shared by all groups.

The walk stops at the earliest of three events: the last word of the line, a group of `FETCH_W` instructions, or a control instruction that the predictor reports as taken. Control instructions are passed to an external branch predictor through a request/response port, and the predictor answers in the same cycle.

When the group is finished, the block pulses a valid signal. In the same step it moves its architectural PC to the last predicted next PC and sets its next-PC to that value plus 4. It also keeps three statistics: a histogram of group sizes, a count of lines read and a count of predicted-taken branches. A request that arrives with the fault flag set produces an empty group and changes none of this state.

Top module: `fetch_group_extractor`

## Requirements
- R1: `fetch_line_addr` equals `fetch_pc` with its low log2(`BLK_BYTES`) bits cleared. It is combinational and does not depend on the state of the block.
- R2: Instruction word k of the line is `line_data[32k+31:32k]`, so byte 4k is the least significant byte. Slot 0 holds the word at index `fetch_pc[log2(BLK_BYTES)-1:2]`, and each later slot holds the following word.
- R3: The group ends after the last word of the line, even when fewer than `FETCH_W` instructions have been taken.
- R4: A group never holds more than `FETCH_W` instructions.
- R5: An instruction is a control instruction only when its bits [31:30] are 2'b11. A non-control instruction never raises `pred_req`, and its predicted next PC is its PC + 4.
- R6: For a control instruction, `pred_req` is high for that cycle, with `pred_pc` and `pred_insn` giving the instruction. If `pred_taken` is high, the instruction takes `pred_target` as its next PC, the group ends after it, and `taken_total` increments by 1.
- R7: A control instruction whose prediction is not taken gets the next PC PC + 4, and the walk continues.
- R8: Slots fill from slot 0. Each slot's sequence number is one more than the previous instruction's, across group boundaries. The sequence counter starts at 0 after reset.
- R9: After a group without fault, `next_pc` equals the last slot's predicted next PC and `next_npc` equals `next_pc` + 4. After a faulted request, `grp_fault` is 1, `grp_count` is 0, and `next_pc` and `next_npc` are unchanged.
- R10: Histogram bucket n (`hist_bins[16n+15:16n]`) increments once for each group without fault that holds n instructions. `lines_total` increments once for each request without fault. A faulted request changes neither.
- R11: After reset, `busy` and `grp_valid` are 0, `next_pc` equals `RESET_PC`, `next_npc` equals `RESET_PC` + 4, and every counter is 0.
- R12: `grp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Start a group; accepted when `busy` is 0 |
| fetch_pc | input | ADDR_W | PC to fetch from (word aligned) |
| line_data | input | BLK_BYTES*8 | Whole cache line, sampled with `fetch_req` |
| line_fault | input | 1 | Translation or read fault for this request |
| fetch_line_addr | output | ADDR_W | Block-aligned cache request address |
| pred_req | output | 1 | Predictor query for the current control instruction |
| pred_pc | output | ADDR_W | PC of the instruction being predicted |
| pred_insn | output | 32 | Instruction being predicted |
| pred_taken | input | 1 | Predictor answer: taken |
| pred_target | input | ADDR_W | Predicted target when taken |
| busy | output | 1 | Walk in progress |
| grp_valid | output | 1 | Group ready (one-cycle pulse) |
| grp_count | output | $clog2(FETCH_W+1) | Number of valid slots |
| grp_fault | output | 1 | Group came from a faulted request |
| grp_insn | output | FETCH_W*32 | Slot instructions, slot i at [32i+31:32i] |
| grp_pc | output | FETCH_W*ADDR_W | Slot PCs |
| grp_npc | output | FETCH_W*ADDR_W | Slot predicted next PCs |
| grp_seq | output | FETCH_W*SEQ_W | Slot sequence numbers |
| next_pc | output | ADDR_W | Architectural fetch PC after the last group |
| next_npc | output | ADDR_W | `next_pc` + 4 |
| hist_bins | output | (FETCH_W+1)*16 | Group-size histogram |
| taken_total | output | 16 | Predicted-taken branch count |
| lines_total | output | 16 | Line reads without fault |

## Verification
The bench targets the three ways a group can end:
- A PC near the end of the line. A design that ignores the line boundary would read past the line or fill all `FETCH_W` slots.
- A taken branch in the middle of the line. A design that got this wrong would keep going after the branch or keep PC + 4 instead of the target.
- A control instruction predicted not taken. A design that got this wrong would stop the group early.

Further tests cover sequence-number continuity across groups, byte order within a word, and a faulted request. A faulty design would overwrite the PC or count the faulted request in the histogram or the line counter.

// File: rtl/fgx_pkg.sv
// Package: shared constants and helpers for the fetch group extractor.
// Assumes 32-bit fixed-width instructions.
package fgx_pkg;
    localparam int INSN_W  = 32;
    localparam int INSN_B  = 4;
    localparam int STAT_W  = 16;

    // Control class: the top two opcode bits both set.
    function automatic logic is_ctrl(input logic [INSN_W-1:0] insn);
        return insn[31:30] == 2'b11;
    endfunction
endpackage

// File: rtl/fgx_walker.sv
// Module: fgx_walker
// Sequencer that walks a captured cache line, one instruction per cycle.
// It queries the predictor, stamps sequence numbers and keeps the
// architectural PC pair. Assumes fetch_pc is word aligned and that the
// predictor answers in the same cycle as the query.
module fgx_walker
    import fgx_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          SEQ_W     = 16,
    parameter int          FETCH_W   = 4,
    parameter int          BLK_BYTES = 64,
    parameter logic [31:0] RESET_PC  = 32'h0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_req,
    input  logic [ADDR_W-1:0]             fetch_pc,
    input  logic [BLK_BYTES*8-1:0]        line_data,
    input  logic                          line_fault,
    output logic                          pred_req,
    output logic [ADDR_W-1:0]             pred_pc,
    output logic [INSN_W-1:0]             pred_insn,
    input  logic                          pred_taken,
    input  logic [ADDR_W-1:0]             pred_target,
    output logic                          busy,
    output logic                          clr,
    output logic                          wr_en,
    output logic [$clog2(FETCH_W+1)-1:0]  wr_idx,
    output logic [INSN_W-1:0]             wr_insn,
    output logic [ADDR_W-1:0]             wr_pc,
    output logic [ADDR_W-1:0]             wr_npc,
    output logic [SEQ_W-1:0]              wr_seq,
    output logic                          grp_valid,
    output logic [$clog2(FETCH_W+1)-1:0]  grp_count,
    output logic                          grp_fault,
    output logic [ADDR_W-1:0]             pc_q,
    output logic [ADDR_W-1:0]             npc_q,
    output logic                          taken_ev,
    output logic                          line_ev
);
    localparam int WORDS  = BLK_BYTES / INSN_B;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int OFF_W  = $clog2(BLK_BYTES);
    localparam int CNT_W  = $clog2(FETCH_W+1);

    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} st_t;

    st_t                    state;
    logic [BLK_BYTES*8-1:0] line_q;
    logic [WIDX_W-1:0]      widx;
    logic [CNT_W-1:0]       cnt;
    logic [ADDR_W-1:0]      cur_pc;
    logic [SEQ_W-1:0]       seq_q;
    logic                   fault_q;

    logic [INSN_W-1:0]      word;
    logic                   ctrl;
    logic                   taken;
    logic [ADDR_W-1:0]      nxt;
    logic                   last;
    logic                   start;

    // Current word selection and next-PC choice for this cycle.
    always_comb begin
        start     = (state == ST_IDLE) && fetch_req;
        word      = line_q[widx*INSN_W +: INSN_W];
        ctrl      = is_ctrl(word);
        pred_req  = (state == ST_WALK) && ctrl;
        pred_pc   = cur_pc;
        pred_insn = word;
        taken     = pred_req && pred_taken;
        nxt       = taken ? pred_target : cur_pc + ADDR_W'(INSN_B);
        last      = taken || (cnt == CNT_W'(FETCH_W-1)) ||
                    (widx == WIDX_W'(WORDS-1));
    end

    // Slot write port and event strobes toward storage and statistics.
    always_comb begin
        wr_en     = (state == ST_WALK);
        wr_idx    = cnt;
        wr_insn   = word;
        wr_pc     = cur_pc;
        wr_npc    = nxt;
        wr_seq    = seq_q;
        clr       = start;
        taken_ev  = taken;
        line_ev   = start && !line_fault;
        busy      = (state != ST_IDLE);
        grp_valid = (state == ST_DONE);
        grp_count = cnt;
        grp_fault = fault_q;
    end

    // Sequencer state, walk position and captured line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            line_q  <= '0;
            widx    <= '0;
            cnt     <= '0;
            cur_pc  <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (fetch_req) begin
                    line_q  <= line_data;
                    widx    <= fetch_pc[OFF_W-1:2];
                    cnt     <= '0;
                    cur_pc  <= fetch_pc;
                    fault_q <= line_fault;
                    state   <= line_fault ? ST_DONE : ST_WALK;
                end
                ST_WALK: begin
                    cnt    <= cnt + 1'b1;
                    widx   <= widx + 1'b1;
                    cur_pc <= nxt;
                    if (last) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Global sequence counter: advances once per extracted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)     seq_q <= '0;
        else if (wr_en) seq_q <= seq_q + 1'b1;
    end

    // Architectural PC pair, updated only when a fault-free group closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= ADDR_W'(RESET_PC);
            npc_q <= ADDR_W'(RESET_PC) + ADDR_W'(INSN_B);
        end else if (wr_en && last) begin
            pc_q  <= nxt;
            npc_q <= nxt + ADDR_W'(INSN_B);
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WALK) |-> (cnt < CNT_W'(FETCH_W)));
    a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1)));
    a_r6_taken_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req && pred_taken) |=> grp_valid);
    a_r9_fault_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && grp_fault) |-> ($stable(pc_q) && grp_count == '0));
    a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> !grp_valid);
    a_r9_npc_pair: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (npc_q == pc_q + ADDR_W'(INSN_B)));
endmodule

// File: rtl/fgx_slot_store.sv
// Module: fgx_slot_store
// Output slot registers for one fetch group. Cleared when a new group
// starts and written one slot per cycle at the index given by the walker.
module fgx_slot_store
    import fgx_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEQ_W   = 16,
    parameter int FETCH_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr_en,
    input  logic [$clog2(FETCH_W+1)-1:0]  wr_idx,
    input  logic [INSN_W-1:0]             wr_insn,
    input  logic [ADDR_W-1:0]             wr_pc,
    input  logic [ADDR_W-1:0]             wr_npc,
    input  logic [SEQ_W-1:0]              wr_seq,
    output logic [FETCH_W*INSN_W-1:0]     grp_insn,
    output logic [FETCH_W*ADDR_W-1:0]     grp_pc,
    output logic [FETCH_W*ADDR_W-1:0]     grp_npc,
    output logic [FETCH_W*SEQ_W-1:0]      grp_seq
);
    localparam int CNT_W = $clog2(FETCH_W+1);

    for (genvar i = 0; i < FETCH_W; i++) begin : g_slot
        // One slot: cleared at group start, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                grp_insn[i*INSN_W +: INSN_W] <= '0;
                grp_pc[i*ADDR_W +: ADDR_W]   <= '0;
                grp_npc[i*ADDR_W +: ADDR_W]  <= '0;
                grp_seq[i*SEQ_W +: SEQ_W]    <= '0;
            end else if (wr_en && wr_idx == CNT_W'(i)) begin
                grp_insn[i*INSN_W +: INSN_W] <= wr_insn;
                grp_pc[i*ADDR_W +: ADDR_W]   <= wr_pc;
                grp_npc[i*ADDR_W +: ADDR_W]  <= wr_npc;
                grp_seq[i*SEQ_W +: SEQ_W]    <= wr_seq;
            end
        end
    end

    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < CNT_W'(FETCH_W)));
endmodule

// File: rtl/fgx_stats.sv
// Module: fgx_stats
// Group-size histogram plus counters of lines read and predicted-taken
// branches. The counters wrap at their width.
module fgx_stats
    import fgx_pkg::*;
#(
    parameter int FETCH_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          done_ok,
    input  logic [$clog2(FETCH_W+1)-1:0]  done_count,
    input  logic                          taken_ev,
    input  logic                          line_ev,
    output logic [(FETCH_W+1)*STAT_W-1:0] hist_bins,
    output logic [STAT_W-1:0]             taken_total,
    output logic [STAT_W-1:0]             lines_total
);
    localparam int CNT_W = $clog2(FETCH_W+1);

    for (genvar b = 0; b <= FETCH_W; b++) begin : g_bin
        // One histogram bucket per possible group size.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hist_bins[b*STAT_W +: STAT_W] <= '0;
            else if (done_ok && done_count == CNT_W'(b))
                hist_bins[b*STAT_W +: STAT_W] <= hist_bins[b*STAT_W +: STAT_W] + 1'b1;
        end
    end

    // Event counters for taken predictions and successful line reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_total <= '0;
            lines_total <= '0;
        end else begin
            if (taken_ev) taken_total <= taken_total + 1'b1;
            if (line_ev)  lines_total <= lines_total + 1'b1;
        end
    end

    a_r10_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        line_ev |=> (lines_total == STAT_W'($past(lines_total) + 1'b1)));
    a_r10_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ev |=> $stable(lines_total));
endmodule

// File: rtl/fetch_group_extractor.sv
// Module: fetch_group_extractor (top)
// Builds a fetch group from one cache line. The line must be presented
// with fetch_req, and the predictor must answer combinationally.
module fetch_group_extractor
    import fgx_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          SEQ_W     = 16,
    parameter int          FETCH_W   = 4,
    parameter int          BLK_BYTES = 64,
    parameter logic [31:0] RESET_PC  = 32'h0000_0100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_req,
    input  logic [ADDR_W-1:0]             fetch_pc,
    input  logic [BLK_BYTES*8-1:0]        line_data,
    input  logic                          line_fault,
    output logic [ADDR_W-1:0]             fetch_line_addr,
    output logic                          pred_req,
    output logic [ADDR_W-1:0]             pred_pc,
    output logic [31:0]                   pred_insn,
    input  logic                          pred_taken,
    input  logic [ADDR_W-1:0]             pred_target,
    output logic                          busy,
    output logic                          grp_valid,
    output logic [$clog2(FETCH_W+1)-1:0]  grp_count,
    output logic                          grp_fault,
    output logic [FETCH_W*32-1:0]         grp_insn,
    output logic [FETCH_W*ADDR_W-1:0]     grp_pc,
    output logic [FETCH_W*ADDR_W-1:0]     grp_npc,
    output logic [FETCH_W*SEQ_W-1:0]      grp_seq,
    output logic [ADDR_W-1:0]             next_pc,
    output logic [ADDR_W-1:0]             next_npc,
    output logic [(FETCH_W+1)*16-1:0]     hist_bins,
    output logic [15:0]                   taken_total,
    output logic [15:0]                   lines_total
);
    localparam int CNT_W = $clog2(FETCH_W+1);
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLK_BYTES - 1);

    logic                 clr, wr_en, taken_ev, line_ev;
    logic [CNT_W-1:0]     wr_idx;
    logic [INSN_W-1:0]    wr_insn;
    logic [ADDR_W-1:0]    wr_pc, wr_npc;
    logic [SEQ_W-1:0]     wr_seq;

    // Block-aligned cache request address.
    always_comb fetch_line_addr = fetch_pc & ~BLK_MASK;

    fgx_walker #(
        .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .FETCH_W(FETCH_W),
        .BLK_BYTES(BLK_BYTES), .RESET_PC(RESET_PC)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .line_data(line_data), .line_fault(line_fault),
        .pred_req(pred_req), .pred_pc(pred_pc), .pred_insn(pred_insn),
        .pred_taken(pred_taken), .pred_target(pred_target),
        .busy(busy), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_insn(wr_insn), .wr_pc(wr_pc), .wr_npc(wr_npc), .wr_seq(wr_seq),
        .grp_valid(grp_valid), .grp_count(grp_count), .grp_fault(grp_fault),
        .pc_q(next_pc), .npc_q(next_npc),
        .taken_ev(taken_ev), .line_ev(line_ev)
    );

    fgx_slot_store #(
        .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .FETCH_W(FETCH_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_insn(wr_insn), .wr_pc(wr_pc), .wr_npc(wr_npc), .wr_seq(wr_seq),
        .grp_insn(grp_insn), .grp_pc(grp_pc), .grp_npc(grp_npc),
        .grp_seq(grp_seq)
    );

    fgx_stats #(
        .FETCH_W(FETCH_W)
    ) u_stats (
        .clk(clk), .rst_n(rst_n),
        .done_ok(grp_valid && !grp_fault), .done_count(grp_count),
        .taken_ev(taken_ev), .line_ev(line_ev),
        .hist_bins(hist_bins), .taken_total(taken_total),
        .lines_total(lines_total)
    );

    a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_line_addr & BLK_MASK) == '0);
endmodule

// File: tb/sim_fetch_group_extractor.sv
// Directed bench for fetch_group_extractor. Each scenario task drives one
// request and checks its own results. The predictor model reports a
// control instruction as taken when bit 0 is set. Its target is
// {16'h0003, insn[15:2], 2'b00}.
module sim_fetch_group_extractor;
    localparam int AW = 32, SW = 16, FW = 4, BB = 64;
    localparam int CW = $clog2(FW+1);

    logic              clk = 0, rst_n = 0;
    logic              fetch_req = 0, line_fault = 0;
    logic [AW-1:0]     fetch_pc = '0;
    logic [BB*8-1:0]   line = '0;
    logic [AW-1:0]     fetch_line_addr, pred_pc, next_pc, next_npc;
    logic              pred_req, pred_taken, busy, grp_valid, grp_fault;
    logic [31:0]       pred_insn;
    logic [AW-1:0]     pred_target;
    logic [CW-1:0]     grp_count;
    logic [FW*32-1:0]  grp_insn;
    logic [FW*AW-1:0]  grp_pc, grp_npc;
    logic [FW*SW-1:0]  grp_seq;
    logic [(FW+1)*16-1:0] hist_bins;
    logic [15:0]       taken_total, lines_total;

    int n_chk = 0, n_bad = 0, n_pred = 0;
    int exp_seq = 0;

    always #10 clk = ~clk;

    // Predictor model.
    always_comb begin
        pred_taken  = pred_insn[0];
        pred_target = {16'h0003, pred_insn[15:2], 2'b00};
    end

    // Count the cycles in which the predictor is queried.
    always @(negedge clk) if (pred_req) n_pred++;

    fetch_group_extractor #(.ADDR_W(AW), .SEQ_W(SW), .FETCH_W(FW), .BLK_BYTES(BB),
                            .RESET_PC(32'h0000_0100)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .line_data(line), .line_fault(line_fault),
        .fetch_line_addr(fetch_line_addr), .pred_req(pred_req),
        .pred_pc(pred_pc), .pred_insn(pred_insn), .pred_taken(pred_taken),
        .pred_target(pred_target), .busy(busy), .grp_valid(grp_valid),
        .grp_count(grp_count), .grp_fault(grp_fault), .grp_insn(grp_insn),
        .grp_pc(grp_pc), .grp_npc(grp_npc), .grp_seq(grp_seq),
        .next_pc(next_pc), .next_npc(next_npc), .hist_bins(hist_bins),
        .taken_total(taken_total), .lines_total(lines_total)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] plain(input int i);
        return 32'h0A00_0000 + 32'(i);
    endfunction

    task automatic fill_plain();
        for (int i = 0; i < BB/4; i++) line[i*32 +: 32] = plain(i);
    endtask

    // Issue one request and wait for the group-valid pulse.
    task automatic run(input logic [31:0] pc, input logic flt);
        int t = 0;
        @(negedge clk);
        fetch_pc = pc; line_fault = flt; fetch_req = 1;
        @(negedge clk);
        fetch_req = 0;
        while (!grp_valid && t < 40) begin @(negedge clk); t++; end
        chk("R12 group valid seen", 32'(grp_valid), 32'd1);
    endtask

    // Check slot s: its instruction, PC, predicted next PC and sequence number.
    task automatic slot(input int s, input logic [31:0] insn, input logic [31:0] pc,
                        input logic [31:0] npc);
        chk("R2 slot insn", grp_insn[s*32 +: 32], insn);
        chk("R5 slot pc", grp_pc[s*AW +: AW], pc);
        chk("R7 slot npc", grp_npc[s*AW +: AW], npc);
        chk("R8 slot seq", 32'(grp_seq[s*SW +: SW]), 32'(exp_seq));
        exp_seq++;
    endtask

    task automatic t_reset();
        chk("R11 busy", 32'(busy), 0);
        chk("R11 valid", 32'(grp_valid), 0);
        chk("R11 pc", next_pc, 32'h100);
        chk("R11 npc", next_npc, 32'h104);
        chk("R11 hist", 32'(|hist_bins), 0);
        chk("R11 lines", 32'(lines_total), 0);
        chk("R11 taken", 32'(taken_total), 0);
    endtask

    task automatic t_width();
        int p0;
        fill_plain();
        fetch_pc = 32'h0000_1000;
        #1 chk("R1 line addr", fetch_line_addr, 32'h1000);
        p0 = n_pred;
        run(32'h1000, 0);
        chk("R4 width count", 32'(grp_count), 4);
        for (int s = 0; s < 4; s++)
            slot(s, plain(s), 32'h1000 + 32'(4*s), 32'h1004 + 32'(4*s));
        chk("R5 no pred query", 32'(n_pred - p0), 0);
        chk("R9 next pc", next_pc, 32'h1010);
        chk("R9 next npc", next_npc, 32'h1014);
        @(negedge clk);
        chk("R12 valid one cycle", 32'(grp_valid), 0);
    endtask

    task automatic t_line_end();
        fill_plain();
        line[13*32 +: 32] = 32'h1122_3344;
        fetch_pc = 32'h0000_1034;
        #1 chk("R1 unaligned line addr", fetch_line_addr, 32'h1000);
        run(32'h1034, 0);
        chk("R3 line end count", 32'(grp_count), 3);
        chk("R2 little endian byte", 32'(grp_insn[7:0]), 32'h44);
        slot(0, 32'h1122_3344, 32'h1034, 32'h1038);
        slot(1, plain(14), 32'h1038, 32'h103C);
        slot(2, plain(15), 32'h103C, 32'h1040);
        chk("R3 next pc", next_pc, 32'h1040);
    endtask

    task automatic t_taken();
        fill_plain();
        line[1*32 +: 32] = 32'hC000_0111;
        run(32'h2000, 0);
        chk("R6 taken count", 32'(grp_count), 2);
        slot(0, plain(0), 32'h2000, 32'h2004);
        slot(1, 32'hC000_0111, 32'h2004, 32'h0003_0110);
        chk("R6 next pc", next_pc, 32'h0003_0110);
        chk("R9 next npc", next_npc, 32'h0003_0114);
        chk("R6 taken total", 32'(taken_total), 1);
    endtask

    task automatic t_not_taken();
        int p0;
        fill_plain();
        line[3*32 +: 32] = 32'hC000_0110;
        p0 = n_pred;
        run(32'h3008, 0);
        chk("R7 count", 32'(grp_count), 4);
        slot(0, plain(2), 32'h3008, 32'h300C);
        slot(1, 32'hC000_0110, 32'h300C, 32'h3010);
        slot(2, plain(4), 32'h3010, 32'h3014);
        slot(3, plain(5), 32'h3014, 32'h3018);
        chk("R6 one query", 32'(n_pred - p0), 1);
        chk("R7 taken total unchanged", 32'(taken_total), 1);
        chk("R9 next pc", next_pc, 32'h3018);
    endtask

    task automatic t_fault();
        fill_plain();
        run(32'h5000, 1);
        chk("R9 fault flag", 32'(grp_fault), 1);
        chk("R9 fault count", 32'(grp_count), 0);
        chk("R9 fault pc held", next_pc, 32'h3018);
        chk("R9 fault npc held", next_npc, 32'h301C);
        chk("R10 lines unchanged", 32'(lines_total), 4);
        chk("R10 bin0 unchanged", 32'(hist_bins[15:0]), 0);
    endtask

    task automatic t_after_fault();
        fill_plain();
        run(32'h4000, 0);
        chk("R9 fault cleared", 32'(grp_fault), 0);
        slot(0, plain(0), 32'h4000, 32'h4004);
        @(negedge clk);
        chk("R10 bin0", 32'(hist_bins[0*16 +: 16]), 0);
        chk("R10 bin1", 32'(hist_bins[1*16 +: 16]), 0);
        chk("R10 bin2", 32'(hist_bins[2*16 +: 16]), 1);
        chk("R10 bin3", 32'(hist_bins[3*16 +: 16]), 1);
        chk("R10 bin4", 32'(hist_bins[4*16 +: 16]), 3);
        chk("R10 lines", 32'(lines_total), 5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_width();
        t_line_end();
        t_taken();
        t_not_taken();
        t_fault();
        t_after_fault();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule